// File: doc/BRIEF.md
# Dual-Line Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources and presents them to a processor on two separate request lines: a normal interrupt line and a fast interrupt line. The two lines share one raw-level vector but each has its own enable mask. A source only reaches a line when its bit is enabled in that line's mask. Software changes a mask through a pair of registers, one that sets bits and one that clears them. This lets independent drivers touch their own bits without a read-modify-write.

Software can also raise an interrupt by itself. A flip-flop that software sets and clears is ORed into source line 0. Status words show both the raw levels and the masked levels for each line. A second instance can be cascaded: its normal-line output is wired into one source input of the first instance. The block has no prioritisation, no vectoring and no edge capture.

Top module: `dual_line_intc`

## Requirements
- R1: After reset both enable masks and the software flip-flop are zero, `irq_o`, `fiq_o` and `rdata` are low, and reads of word indices 2 and 10 return zero.
- R2: The raw-level vector equals `src_in`, with bit 0 ORed with the software flip-flop. It reads back at word index 1 and again at word index 9.
- R3: `irq_o` is high exactly when (raw level AND normal mask) is non-zero. It is registered, so it reflects the source and mask state of the previous clock edge.
- R4: `fiq_o` is high exactly when (raw level AND fast mask) is non-zero. It uses the same one-cycle registered timing as R3.
- R5: A write to word index 2 ORs `wdata` into the normal mask. A read of index 2 returns that mask.
- R6: A write to word index 3 clears every bit of the normal mask that `wdata` holds as one. All other bits are kept.
- R7: Word indices 10 (set) and 11 (clear) act on the fast mask the same way. A read of index 10 returns the fast mask.
- R8: A write to index 4 with `wdata[0]`=1 sets the software flip-flop. A write to index 5 with `wdata[0]`=1 clears it. Either write with `wdata[0]`=0 has no effect. A read of index 4 returns raw bit 0 in bit 0 and zero in all other bits.
- R9: A read of index 0 returns raw AND normal mask. A read of index 8 returns raw AND fast mask.
- R10: Reads of the write-only indices 3, 5 and 11 return zero, and so do reads of any undecoded index.
- R11: Writes to the status indices 0, 1, 8 and 9 change neither mask nor the software flip-flop.
- R12: `rdata` is loaded at the clock edge on which `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word index of the register |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A mask write is captured at the edge on which `wr_en` is high, and the request lines show the new mask one edge later. A change on `src_in` reaches the request lines after a single edge, and read data is ready one edge after `rd_en`. Each bench task drives inputs on the falling clock edge and samples on a later falling edge, counted against these latencies. The source-to-output path is checked on both sides of its edge: the old value just after the input moves, and the new value one edge later.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Word indices of the register file
  localparam int IDX_IRQ_STAT  = 0;
  localparam int IDX_RAW_A     = 1;
  localparam int IDX_IRQ_SET   = 2;
  localparam int IDX_IRQ_CLR   = 3;
  localparam int IDX_SOFT_ON   = 4;
  localparam int IDX_SOFT_OFF  = 5;
  localparam int IDX_FIQ_STAT  = 8;
  localparam int IDX_RAW_B     = 9;
  localparam int IDX_FIQ_SET   = 10;
  localparam int IDX_FIQ_CLR   = 11;
  localparam int NUM_LINES     = 2;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W       = 32,
  parameter int ADDR_W  = 6,
  parameter int SET_IDX = 2,
  parameter int CLR_IDX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      mask_q
);
  logic hit_set, hit_clr;
  assign hit_set = wr_en && (addr == ADDR_W'(SET_IDX));
  assign hit_clr = wr_en && (addr == ADDR_W'(CLR_IDX));

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (hit_set) mask_q <= mask_q | wdata;
    else if (hit_clr) mask_q <= mask_q & ~wdata;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    hit_set |=> ((mask_q & $past(wdata)) == $past(wdata))); // R5 R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    hit_clr |=> ((mask_q & $past(wdata)) == '0)); // R6 R7
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  output logic         req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= |(raw & mask);
  end

  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == '0) |-> !req_q); // R3 R4
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  input  logic [W-1:0]      src_in,
  input  logic [W-1:0]      irq_mask,
  input  logic [W-1:0]      fiq_mask,
  output logic [W-1:0]      raw_o,
  output logic [W-1:0]      rdata
);
  logic soft_q;
  logic [W-1:0] rd_mux;
  logic soft_on, soft_off;

  assign soft_on  = wr_en && wbit0 && (addr == ADDR_W'(IDX_SOFT_ON));
  assign soft_off = wr_en && wbit0 && (addr == ADDR_W'(IDX_SOFT_OFF));

  always_ff @(posedge clk) begin
    if (rst)           soft_q <= 1'b0;
    else if (soft_on)  soft_q <= 1'b1;
    else if (soft_off) soft_q <= 1'b0;
  end

  assign raw_o = src_in | {{(W-1){1'b0}}, soft_q};

  always_comb begin
    case (addr)
      ADDR_W'(IDX_IRQ_STAT): rd_mux = raw_o & irq_mask;
      ADDR_W'(IDX_RAW_A):    rd_mux = raw_o;
      ADDR_W'(IDX_IRQ_SET):  rd_mux = irq_mask;
      ADDR_W'(IDX_SOFT_ON):  rd_mux = {{(W-1){1'b0}}, raw_o[0]};
      ADDR_W'(IDX_FIQ_STAT): rd_mux = raw_o & fiq_mask;
      ADDR_W'(IDX_RAW_B):    rd_mux = raw_o;
      ADDR_W'(IDX_FIQ_SET):  rd_mux = fiq_mask;
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(IDX_IRQ_CLR) || addr == ADDR_W'(IDX_SOFT_OFF)
               || addr == ADDR_W'(IDX_FIQ_CLR))) |=> (rdata == '0)); // R10
  AST_SOFT_RAISE: assert property (@(posedge clk) disable iff (rst)
    soft_on |=> raw_o[0]); // R8
  AST_SOFT_DROP: assert property (@(posedge clk) disable iff (rst)
    soft_off |=> (raw_o[0] == src_in[0])); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R12
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] mask_w [NUM_LINES];
  logic               req_w  [NUM_LINES];

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    localparam int SET_I = (gi == 0) ? IDX_IRQ_SET : IDX_FIQ_SET;
    localparam int CLR_I = (gi == 0) ? IDX_IRQ_CLR : IDX_FIQ_CLR;

    intc_mask_bank #(.W(NUM_SRC), .ADDR_W(ADDR_W), .SET_IDX(SET_I), .CLR_IDX(CLR_I)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .mask_q(mask_w[gi])
    );

    intc_out_stage #(.W(NUM_SRC)) u_out (
      .clk(clk), .rst(rst), .raw(raw), .mask(mask_w[gi]), .req_q(req_w[gi])
    );
  end

  intc_regif #(.W(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wbit0(wdata[0]), .src_in(src_in), .irq_mask(mask_w[0]),
    .fiq_mask(mask_w[1]), .raw_o(raw), .rdata(rdata)
  );

  assign irq_o = req_w[0];
  assign fiq_o = req_w[1];

  logic ro_write;
  assign ro_write = wr_en && (addr == ADDR_W'(IDX_IRQ_STAT) || addr == ADDR_W'(IDX_RAW_A)
                              || addr == ADDR_W'(IDX_FIQ_STAT) || addr == ADDR_W'(IDX_RAW_B));

  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ro_write |=> ($stable(mask_w[0]) && $stable(mask_w[1]))); // R11
endmodule

// File: tb/dual_line_intc_bench.sv
module dual_line_intc_bench;
  localparam int N  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  src_in;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          irq_o, fiq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  dual_line_intc #(.NUM_SRC(N), .ADDR_W(AW)) u_dual_line_intc (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [N-1:0] v);
    @(negedge clk);
    addr = AW'(idx); wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int idx, output logic [N-1:0] v);
    @(negedge clk);
    addr = AW'(idx); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1 rdata", rdata, '0);
    check("R1 irq_o", N'(irq_o), '0);
    check("R1 fiq_o", N'(fiq_o), '0);
    rd(2, v);  check("R1 irq mask", v, '0);
    rd(10, v); check("R1 fiq mask", v, '0);
  endtask

  task automatic t_raw();
    logic [N-1:0] v;
    @(negedge clk); src_in = 32'hA5A5_0F00;
    rd(1, v); check("R2 raw idx1", v, 32'hA5A5_0F00);
    rd(9, v); check("R2 raw idx9", v, 32'hA5A5_0F00);
  endtask

  task automatic t_irq();
    logic [N-1:0] v;
    wr(2, 32'h0000_0F00);
    rd(2, v); check("R5 set", v, 32'h0000_0F00);
    wr(2, 32'h0000_0001);
    rd(2, v); check("R5 or", v, 32'h0000_0F01);
    check("R3 irq high", N'(irq_o), N'(1));
    check("R4 fiq low", N'(fiq_o), '0);
    rd(0, v); check("R9 irq stat", v, 32'h0000_0F00);
    // one-cycle latency from source to output
    @(negedge clk); src_in = '0;
    #1 check("R3 irq old value", N'(irq_o), N'(1));
    settle(); check("R3 irq after edge", N'(irq_o), '0);
    src_in = 32'hA5A5_0F00;
    #1 check("R3 irq still low", N'(irq_o), '0);
    settle(); check("R3 irq back", N'(irq_o), N'(1));
    wr(3, 32'h0000_0300);
    rd(2, v); check("R6 clr partial", v, 32'h0000_0C01);
    wr(3, 32'hFFFF_FFFF);
    rd(2, v); check("R6 clr all", v, '0);
    check("R3 irq low", N'(irq_o), '0);
  endtask

  task automatic t_fiq();
    logic [N-1:0] v;
    wr(10, 32'h8000_0000);
    settle();
    check("R4 fiq high", N'(fiq_o), N'(1));
    check("R3 irq low", N'(irq_o), '0);
    rd(10, v); check("R7 fiq mask", v, 32'h8000_0000);
    rd(8, v);  check("R9 fiq stat", v, 32'h8000_0000);
    wr(11, 32'h8000_0000);
    rd(10, v); check("R7 fiq clr", v, '0);
    check("R4 fiq low", N'(fiq_o), '0);
  endtask

  task automatic t_soft();
    logic [N-1:0] v;
    @(negedge clk); src_in = '0;
    wr(2, 32'h1);
    wr(4, 32'h2);
    rd(4, v); check("R8 bit0 zero ignored", v, '0);
    check("R8 irq low", N'(irq_o), '0);
    wr(4, 32'h1);
    rd(4, v); check("R8 soft set", v, 32'h1);
    rd(1, v); check("R2 raw soft", v, 32'h1);
    check("R3 irq soft", N'(irq_o), N'(1));
    wr(5, 32'h0);
    rd(4, v); check("R8 off bit0 zero ignored", v, 32'h1);
    wr(5, 32'h1);
    rd(1, v); check("R8 soft clr", v, '0);
    check("R3 irq soft clr", N'(irq_o), '0);
    @(negedge clk); src_in = 32'h8000_0001;
    rd(4, v); check("R8 idx4 input bit0 only", v, 32'h1);
    @(negedge clk); src_in = '0;
    wr(3, 32'h1);
  endtask

  task automatic t_wo_reads();
    logic [N-1:0] v;
    @(negedge clk); src_in = 32'hFFFF_FFFF;
    wr(2, 32'h0000_FFFF);
    wr(10, 32'h0000_FF00);
    rd(3, v);  check("R10 idx3", v, '0);
    rd(5, v);  check("R10 idx5", v, '0);
    rd(11, v); check("R10 idx11", v, '0);
    rd(6, v);  check("R10 idx6", v, '0);
    rd(63, v); check("R10 idx63", v, '0);
  endtask

  task automatic t_ro_writes();
    logic [N-1:0] v;
    @(negedge clk); src_in = '0;
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    rd(2, v);  check("R11 irq mask kept", v, 32'h0000_FFFF);
    rd(10, v); check("R11 fiq mask kept", v, 32'h0000_FF00);
    rd(4, v);  check("R11 soft kept", v, '0);
  endtask

  task automatic t_hold();
    logic [N-1:0] v;
    rd(2, v);
    settle(); settle();
    check("R12 rdata holds", rdata, 32'h0000_FFFF);
  endtask

  initial begin
    rst = 1'b1; src_in = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw();
    t_irq();
    t_fiq();
    t_soft();
    t_wo_reads();
    t_ro_writes();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule